// File: doc/BRIEF.md
# Doze-Mode Clock Ratio Controller

This block lets a processor core run slower than the peripherals. It holds a 16-bit control word. The word carries a recover-on-interrupt flag, a 3-bit reduction code, a reduction enable and a 3-bit postscaler code for the fast RC oscillator. Everything is clocked by the peripheral clock. The block makes two clock-enable strobes: `cpu_ce` marks the peripheral-clock cycles in which the processor may advance, and `osc_ce` marks the postscaled oscillator ticks. The block gates no clock.

Software writes the word through a byte-lane write port and reads it back in full on a read port. Two interlocks guard the reduction enable. While the enable is set, the reduction code cannot be changed. The enable cannot be set while the reduction code is zero. When recover-on-interrupt is armed, an interrupt event drops the enable, and the processor returns to full speed.

Top module: `dz_clock_ratio`

## Requirements
- R1: The read port returns {roi[15], ratio[14:12], enable[11], post[10:8], 8'h00}. Bits 7..0 always read as zero.
- R2: After reset the word reads 16'h3000: roi=0, ratio=3, enable=0, post=0.
- R3: With the enable at 1, `cpu_ce` is high in one cycle out of every 2^ratio (ratio code 0..7 gives 1..128).
- R4: With the enable at 0, `cpu_ce` is high in every cycle, whatever the ratio field holds.
- R5: While the enable is 1 before a write, the write leaves the ratio field unchanged. The other fields are still written.
- R6: A write that sets bit 11 is judged against the ratio the same write produces. If that ratio is 0, the enable stays 0. A single write from enable=0 can load a nonzero ratio and set the enable together.
- R7: An interrupt event clears the enable when roi is 1. When roi is 0, an interrupt leaves the enable unchanged.
- R8: If an interrupt event (with roi=1 before the write) arrives in the same cycle as a write that sets the enable, the enable ends up 0.
- R9: `osc_ce` is high in one cycle out of every D cycles, where post codes 0..7 give D = 1, 2, 4, 8, 16, 32, 64, 256.
- R10: When the effective code of either strobe changes, its counter restarts. The first pulse then comes D cycles after the update edge, not earlier.
- R11: Only byte lane 1 (wr_be[1], bits 15..8) writes the word. A write with only wr_be[0] set changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_be | input | 2 | Byte-lane enables |
| wr_data | input | 16 | Write data |
| irq_evt | input | 1 | Interrupt event, one cycle |
| rd_data | output | 16 | Current control word |
| cpu_ce | output | 1 | Processor clock-enable strobe |
| osc_ce | output | 1 | Postscaled oscillator enable strobe |

## Verification
Every ratio code from 1 to 7 is loaded with the enable in a single write. The strobe is then checked cycle by cycle over two full periods, starting at the update edge. This separates a wrong power, an off-by-one count and a missing counter restart. The postscaler is swept over all eight codes in the same way, so the divide-by-256 exception at code 7 is distinct from a plain 128. The interlock writes are arranged so that a check based on the pre-write ratio gives a different word from one based on the post-write ratio. Interrupts are sent with roi both clear and set, and once together with a write that sets the enable, to show which of the two wins.

// File: rtl/dz_clk_pkg.sv
package dz_clk_pkg;
  localparam int REG_W     = 16;
  localparam int CODE_W    = 3;
  localparam int MAX_DIV   = 256;
  localparam int ROI_BIT   = 15;
  localparam int RATIO_LSB = 12;
  localparam int EN_BIT    = 11;
  localparam int POST_LSB  = 8;
  localparam int KIND_DOZE = 0;
  localparam int KIND_POST = 1;

  typedef struct packed {
    logic              roi;
    logic [CODE_W-1:0] ratio;
    logic              en;
    logic [CODE_W-1:0] post;
  } dz_ctrl_t;

  // Divide factor for a code: powers of two, with the postscaler top code at 256
  function automatic int unsigned div_of(input int kind, input logic [CODE_W-1:0] code);
    if (kind == KIND_POST && code == {CODE_W{1'b1}}) return 256;
    return 32'd1 << code;
  endfunction
endpackage

// File: rtl/dz_ctrl_reg.sv
module dz_ctrl_reg
  import dz_clk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_be,
  input  logic [REG_W-1:0] wr_data,
  input  logic             irq_evt,
  output dz_ctrl_t         ctrl,
  output logic             wr_hi,
  output logic             irq_clear,
  output logic             en_blocked
);
  dz_ctrl_t          ctrl_q;
  logic [CODE_W-1:0] nxt_ratio;
  logic              en_req;
  logic              nxt_en;

  assign wr_hi     = wr_en && wr_be[1];
  assign irq_clear = irq_evt && ctrl_q.roi;
  assign en_req    = wr_data[EN_BIT];

  always_comb begin
    nxt_ratio = ctrl_q.ratio;
    if (wr_hi && !ctrl_q.en) nxt_ratio = wr_data[RATIO_LSB +: CODE_W];
  end

  assign en_blocked = wr_hi && en_req && (nxt_ratio == '0);

  always_comb begin
    nxt_en = ctrl_q.en;
    if (irq_clear)  nxt_en = 1'b0;
    else if (wr_hi) nxt_en = en_req && (nxt_ratio != '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q.roi   <= 1'b0;
      ctrl_q.ratio <= CODE_W'(3);
      ctrl_q.en    <= 1'b0;
      ctrl_q.post  <= '0;
    end else begin
      ctrl_q.ratio <= nxt_ratio;
      ctrl_q.en    <= nxt_en;
      if (wr_hi) begin
        ctrl_q.roi  <= wr_data[ROI_BIT];
        ctrl_q.post <= wr_data[POST_LSB +: CODE_W];
      end
    end
  end

  assign ctrl = ctrl_q;

  p_ratio_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q.en |=> $stable(ctrl_q.ratio));
  p_enable_blocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    en_blocked |=> !ctrl_q.en);
  p_enable_needs_ratio_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q.en |-> (ctrl_q.ratio != '0));
  p_irq_recover_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_clear |=> !ctrl_q.en);
  p_irq_no_effect_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_evt && !ctrl_q.roi && !wr_hi) |=> $stable(ctrl_q.en));
  p_irq_beats_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clear && wr_hi && en_req) |=> !ctrl_q.en);
endmodule

// File: rtl/dz_pulse_gen.sv
module dz_pulse_gen
  import dz_clk_pkg::*;
#(
  parameter int KIND      = KIND_DOZE,
  parameter int CODE_BITS = CODE_W,
  parameter int DIV_MAX   = MAX_DIV
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CODE_BITS-1:0] code,
  output logic                 ce
);
  localparam int CNT_W = $clog2(DIV_MAX);
  localparam int PER_W = CNT_W + 1;

  logic [CODE_BITS-1:0] code_q;
  logic [CNT_W-1:0]     cnt_q;
  logic [CNT_W-1:0]     ecnt;
  logic [PER_W-1:0]     period;
  logic                 restart;
  logic                 hit;

  assign period  = PER_W'(div_of(KIND, code));
  assign restart = (code != code_q);
  assign ecnt    = restart ? '0 : cnt_q;
  assign hit     = ({1'b0, ecnt} == (period - PER_W'(1)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_q <= '0;
      cnt_q  <= '0;
    end else begin
      code_q <= code;
      cnt_q  <= hit ? '0 : ecnt + CNT_W'(1);
    end
  end

  assign ce = hit;

  p_cnt_in_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !restart |-> ({1'b0, cnt_q} < period));
  p_restart_full_period_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && period > PER_W'(2)) |=> (restart || !ce));
endmodule

// File: rtl/dz_clock_ratio.sv
module dz_clock_ratio
  import dz_clk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_be,
  input  logic [REG_W-1:0] wr_data,
  input  logic             irq_evt,
  output logic [REG_W-1:0] rd_data,
  output logic             cpu_ce,
  output logic             osc_ce
);
  dz_ctrl_t          ctrl;
  logic              wr_hi;
  logic              irq_clear;
  logic              en_blocked;
  logic [CODE_W-1:0] cpu_code;

  dz_ctrl_reg u_reg (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_be      (wr_be),
    .wr_data    (wr_data),
    .irq_evt    (irq_evt),
    .ctrl       (ctrl),
    .wr_hi      (wr_hi),
    .irq_clear  (irq_clear),
    .en_blocked (en_blocked)
  );

  assign cpu_code = ctrl.en ? ctrl.ratio : '0;

  dz_pulse_gen #(.KIND(KIND_DOZE)) u_cpu_gen (
    .clk   (clk),
    .rst_n (rst_n),
    .code  (cpu_code),
    .ce    (cpu_ce)
  );

  dz_pulse_gen #(.KIND(KIND_POST)) u_osc_gen (
    .clk   (clk),
    .rst_n (rst_n),
    .code  (ctrl.post),
    .ce    (osc_ce)
  );

  assign rd_data = {ctrl.roi, ctrl.ratio, ctrl.en, ctrl.post, 8'h00};

  p_full_speed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.en |-> cpu_ce);
  p_low_lane_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_be == 2'b01 && !irq_evt) |=> $stable(rd_data));
endmodule

// File: tb/test_dz_clock_ratio.sv
module test_dz_clock_ratio;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_be = 2'b00;
  logic [15:0] wr_data = '0;
  logic        irq_evt = 1'b0;
  logic [15:0] rd_data;
  logic        cpu_ce;
  logic        osc_ce;
  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  dz_clock_ratio i_dz_clock_ratio (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_be(wr_be),
    .wr_data(wr_data), .irq_evt(irq_evt), .rd_data(rd_data),
    .cpu_ce(cpu_ce), .osc_ce(osc_ce)
  );

  function automatic int exp_div(input bit post, input int code);
    if (post && code == 7) return 256;
    return 1 << code;
  endfunction

  task automatic check_word(input string req, input logic [15:0] exp);
    @(negedge clk);
    tests++;
    if (rd_data !== exp) begin
      fails++;
      $display("FAIL %s: rd_data=%h expected %h", req, rd_data, exp);
    end
  endtask

  task automatic wr(input logic [1:0] be, input logic [15:0] d, input bit irq);
    @(negedge clk);
    wr_en = 1'b1; wr_be = be; wr_data = d; irq_evt = irq;
    @(posedge clk);
    #1 wr_en = 1'b0; wr_be = 2'b00; irq_evt = 1'b0;
  endtask

  task automatic pulse_irq();
    @(negedge clk);
    irq_evt = 1'b1;
    @(posedge clk);
    #1 irq_evt = 1'b0;
  endtask

  // Called right after the update edge; cycle k=1 is the first one after it
  task automatic check_period(input string req, input bit osc, input int n);
    int bad = 0;
    logic got = 1'b0;
    logic exp = 1'b0;
    logic bad_got = 1'b0;
    logic bad_exp = 1'b0;
    for (int k = 1; k <= 2 * n; k++) begin
      @(negedge clk);
      got = osc ? osc_ce : cpu_ce;
      exp = (k % n) == 0;
      if (got !== exp && bad == 0) begin bad_got = got; bad_exp = exp; bad = k; end
    end
    tests++;
    if (bad != 0) begin
      fails++;
      $display("FAIL %s: %s period %0d cycle %0d ce=%b expected %b",
               req, osc ? "osc" : "cpu", n, bad, bad_got, bad_exp);
    end
  endtask

  task automatic t_reset();
    check_word("R2", 16'h3000);
    tests++;
    if (cpu_ce !== 1'b1 || osc_ce !== 1'b1) begin
      fails++;
      $display("FAIL R2/R4: cpu_ce=%b osc_ce=%b expected 1 1", cpu_ce, osc_ce);
    end
  endtask

  task automatic t_layout();
    wr(2'b11, 16'hFFFF, 1'b0);
    check_word("R1", 16'hFF00);
    wr(2'b11, 16'h0000, 1'b0);      // enable was 1: ratio 7 kept
    check_word("R1/R5", 16'h7000);
    wr(2'b11, 16'h2000, 1'b0);
    check_word("R1", 16'h2000);
  endtask

  task automatic t_low_lane();
    wr(2'b01, 16'hFFFF, 1'b0);
    check_word("R11 low lane", 16'h2000);
  endtask

  task automatic t_ratio_sweep();
    for (int c = 1; c < 8; c++) begin
      wr(2'b11, 16'((c << 12) | 16'h0800), 1'b0);
      check_period("R3/R10", 1'b0, exp_div(1'b0, c));
      wr(2'b11, 16'h0000, 1'b0);
    end
  endtask

  task automatic t_enable_off();
    wr(2'b11, 16'h5000, 1'b0);
    check_period("R4", 1'b0, 1);
  endtask

  task automatic t_lock();
    wr(2'b11, 16'h3800, 1'b0);
    wr(2'b11, 16'h6800, 1'b0);
    check_word("R5 locked", 16'h3800);
    wr(2'b11, 16'h6000, 1'b0);
    check_word("R5 locked on clear", 16'h3000);
  endtask

  task automatic t_zero_ratio();
    wr(2'b11, 16'h0800, 1'b0);
    check_word("R6 blocked", 16'h0000);
    wr(2'b11, 16'h4800, 1'b0);
    check_word("R6 combined", 16'h4800);
  endtask

  task automatic t_irq();
    pulse_irq();
    check_word("R7 roi=0", 16'h4800);
    wr(2'b11, 16'hC800, 1'b0);
    check_word("R7 arm", 16'hC800);
    pulse_irq();
    check_period("R7 full speed", 1'b0, 1);
    check_word("R7 roi=1", 16'hC000);
  endtask

  task automatic t_irq_prio();
    wr(2'b11, 16'hC800, 1'b1);
    check_word("R8", 16'hC000);
  endtask

  task automatic t_post_sweep();
    for (int p = 1; p < 8; p++) begin
      wr(2'b11, 16'(p << 8), 1'b0);
      check_period("R9/R10", 1'b1, exp_div(1'b1, p));
    end
    wr(2'b11, 16'h0000, 1'b0);
    check_period("R9", 1'b1, 1);
  endtask

  initial begin
    #(20 * 200000);
    tests++; fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_layout();
    t_low_lane();
    t_ratio_sweep();
    t_enable_off();
    t_lock();
    t_zero_ratio();
    t_irq();
    t_irq_prio();
    t_post_sweep();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule